// File: doc/BRIEF.md
# Morse Letter Pulse Transmitter

This block turns a three-bit letter selection into a timed serial Morse stream. A start pulse picks one of eight letters and loads its 12-bit dot/dash pattern into a shift register. The pattern then leaves the block one bit at a time, with each bit held for half a second. A one-cycle strobe marks the moment each new bit appears.

A single down-counting divider sets the half-second pacing. Its length comes from the clock frequency parameter, so the same block works at any board clock, and a simulation can set the frequency to a few hertz so that each bit lasts only a couple of cycles. Once the twelfth bit has been sent, the output rests at 0 and the strobe stays quiet until the next start.

Top module: `morse_letter_tx`

## Requirements
- R1: `letter_i` selects the letter as follows: code 0 is A, 1 is B, 2 is C, 3 is D, 4 is E, 5 is F, 6 is G and 7 is H.
- R2: Each letter is encoded as a 12-bit pattern. A dot is one 1, a dash is three 1s, neighbouring elements are separated by one 0, and the remaining positions are 0. The patterns are A=101110000000, B=111010101000, C=111010111010, D=111010100000, E=100000000000, F=101011101000, G=111011101000, H=101010100000.
- R3: The pattern is sent most significant bit first. When `start_i` is sampled high at a clock edge, bit 11 is on `serial_o` and `bit_strobe_o` is high from that edge onward.
- R4: Each later bit appears exactly CLK_HZ/2 clock cycles after the previous one. This is half a second of clock.
- R5: `bit_strobe_o` is high for exactly one cycle for each new bit, and there are exactly 12 strobes per start.
- R6: After the twelfth bit, `serial_o` drops to 0 at the next half-second tick. It then stays at 0, with no further strobes, until the next start.
- R7: A synchronous active-high `rst_i` clears `serial_o` and `bit_strobe_o` to 0. Reset takes priority over `start_i`.
- R8: A start during a transmission abandons it and begins the newly selected letter from its first bit, with a full half-second for that bit.
- R9: `serial_o` changes only on a cycle where `bit_strobe_o` is high, apart from reset and the single drop to 0 described in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at CLK_HZ |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load the selected letter and begin sending |
| letter_i | input | 3 | Letter code, 0 = A through 7 = H |
| serial_o | output | 1 | Current Morse bit (1 = key down) |
| bit_strobe_o | output | 1 | One-cycle pulse when a new bit appears |

## Verification
A wrong internal state shows up at the ports within one bit period. A bad pattern entry or a bad shift gives a wrong `serial_o` value at the very next strobe. A divider that is off by one moves the strobe spacing away from CLK_HZ/2 on the second bit. A bit counter that is wrong gives a thirteenth strobe, or a missing twelfth one, about twelve half-second periods after start. The bench compares every strobed bit against an independently written table, measures the gap between strobes, and watches for strobes that should not occur after completion and after reset.

// File: rtl/morse_pkg.sv
package morse_pkg;
   localparam int MORSE_LETTERS = 8;
   localparam int MAX_ELEMS     = 4;

   typedef enum logic [2:0] {
      LTR_A, LTR_B, LTR_C, LTR_D, LTR_E, LTR_F, LTR_G, LTR_H
   } letter_e;

   // len: number of elements; dash[e] set when element e (first = 0) is a dash
   typedef struct packed {
      logic [2:0] len;
      logic [3:0] dash;
   } glyph_t;

   function automatic glyph_t glyph_of(letter_e l);
      glyph_t g;
      case (l)
         LTR_A:   g = '{len: 3'd2, dash: 4'b0010};
         LTR_B:   g = '{len: 3'd4, dash: 4'b0001};
         LTR_C:   g = '{len: 3'd4, dash: 4'b0101};
         LTR_D:   g = '{len: 3'd3, dash: 4'b0001};
         LTR_E:   g = '{len: 3'd1, dash: 4'b0000};
         LTR_F:   g = '{len: 3'd4, dash: 4'b0100};
         LTR_G:   g = '{len: 3'd3, dash: 4'b0011};
         default: g = '{len: 3'd4, dash: 4'b0000};
      endcase
      return g;
   endfunction
endpackage

// File: rtl/morse_rate_div.sv
module morse_rate_div #(
   parameter int TICKS = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic restart_i,
   input  logic run_i,
   output logic tick_o
);
   if (TICKS < 1) begin : g_bad_ticks
      $error("morse_rate_div: TICKS must be at least 1");
   end

   if (TICKS == 1) begin : g_every_cycle
      assign tick_o = run_i && !restart_i;
   end else begin : g_counter
      localparam int CW = $clog2(TICKS);
      localparam logic [CW-1:0] RELOAD = CW'(TICKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i) begin
         if (rst_i)                cnt_q <= '0;
         else if (restart_i)       cnt_q <= RELOAD;
         else if (run_i) begin
            if (cnt_q == '0)       cnt_q <= RELOAD;
            else                   cnt_q <= cnt_q - 1'b1;
         end
      end

      assign tick_o = run_i && !restart_i && (cnt_q == '0);
   end
endmodule

// File: rtl/morse_pattern_rom.sv
module morse_pattern_rom
   import morse_pkg::*;
#(
   parameter int PAT_W = 12
) (
   input  logic [2:0]       letter_i,
   output logic [PAT_W-1:0] pattern_o
);
   localparam int ACC_W = PAT_W + 1;

   if (PAT_W < 12) begin : g_bad_width
      $error("morse_pattern_rom: PAT_W must be at least 12");
   end

   // Pack elements back to back, then left-align, dropping the final gap bit.
   function automatic logic [PAT_W-1:0] build(glyph_t g);
      logic [ACC_W-1:0] acc;
      int used;
      acc  = '0;
      used = 0;
      for (int e = 0; e < MAX_ELEMS; e++) begin
         if (e < int'(g.len)) begin
            if (g.dash[e]) begin
               acc  = (acc << 4) | ACC_W'(4'b1110);
               used = used + 4;
            end else begin
               acc  = (acc << 2) | ACC_W'(2'b10);
               used = used + 2;
            end
         end
      end
      acc = acc << (ACC_W - used);
      return acc[ACC_W-1:1];
   endfunction

   logic [PAT_W-1:0] table_w [MORSE_LETTERS];

   for (genvar i = 0; i < MORSE_LETTERS; i++) begin : g_entry
      assign table_w[i] = build(glyph_of(letter_e'(i)));
   end

   assign pattern_o = table_w[letter_i];
endmodule

// File: rtl/morse_shifter.sv
module morse_shifter #(
   parameter int PAT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [PAT_W-1:0] data_i,
   input  logic             shift_i,
   output logic             msb_o
);
   logic [PAT_W-1:0] sreg_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)        sreg_q <= '0;
      else if (load_i)  sreg_q <= data_i;
      else if (shift_i) sreg_q <= {sreg_q[PAT_W-2:0], 1'b0};
   end

   assign msb_o = sreg_q[PAT_W-1];
endmodule

// File: rtl/morse_letter_tx.sv
module morse_letter_tx #(
   parameter int CLK_HZ = 50_000_000,
   parameter int PAT_W  = 12
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       start_i,
   input  logic [2:0] letter_i,
   output logic       serial_o,
   output logic       bit_strobe_o
);
   localparam int TICKS = CLK_HZ / 2;
   localparam int CNT_W = $clog2(PAT_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_W);

   if (CLK_HZ < 2) begin : g_bad_clk
      $error("morse_letter_tx: CLK_HZ must be at least 2");
   end

   logic             load_w;
   logic             tick_w;
   logic             active_q;
   logic [CNT_W-1:0] sent_q;
   logic             strobe_q;
   logic [PAT_W-1:0] pattern_w;

   assign load_w = start_i && !rst_i;

   morse_pattern_rom #(.PAT_W(PAT_W)) u_rom (
      .letter_i  (letter_i),
      .pattern_o (pattern_w)
   );

   morse_rate_div #(.TICKS(TICKS)) u_div (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (load_w),
      .run_i     (active_q),
      .tick_o    (tick_w)
   );

   morse_shifter #(.PAT_W(PAT_W)) u_shift (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (load_w),
      .data_i  (pattern_w),
      .shift_i (tick_w),
      .msb_o   (serial_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         active_q <= 1'b0;
         sent_q   <= '0;
         strobe_q <= 1'b0;
      end else if (load_w) begin
         active_q <= 1'b1;
         sent_q   <= CNT_W'(1);
         strobe_q <= 1'b1;
      end else if (tick_w) begin
         if (sent_q == LAST) begin
            active_q <= 1'b0;
            strobe_q <= 1'b0;
         end else begin
            sent_q   <= sent_q + 1'b1;
            strobe_q <= 1'b1;
         end
      end else begin
         strobe_q <= 1'b0;
      end
   end

   assign bit_strobe_o = strobe_q;
endmodule

// File: rtl/morse_letter_tx_chk.sv
module morse_letter_tx_chk #(
   parameter int PAT_W = 12,
   parameter int TICKS = 2
) (
   input logic clk_i,
   input logic rst_i,
   input logic start_i,
   input logic serial_o,
   input logic bit_strobe_o
);
   int unsigned gap_q;
   int unsigned nstrobe_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || bit_strobe_o) gap_q <= 0;
      else                       gap_q <= gap_q + 1;
      if (rst_i || start_i)      nstrobe_q <= 0;
      else if (bit_strobe_o)     nstrobe_q <= nstrobe_q + 1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk_i)
      rst_i |=> (!bit_strobe_o && !serial_o));                        // R7

   AST_START_FIRST_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> (bit_strobe_o && serial_o));                        // R3

   AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (TICKS > 1 && bit_strobe_o && !start_i) |=> !bit_strobe_o);     // R5

   AST_STROBE_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
      bit_strobe_o |-> (nstrobe_q < PAT_W));                          // R5

   AST_BIT_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
      (bit_strobe_o && !$past(start_i) && !$past(rst_i)) |-> (gap_q == TICKS - 1)); // R4

   AST_SERIAL_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (!bit_strobe_o && !$past(rst_i) && serial_o) |-> $stable(serial_o)); // R9
endmodule

bind morse_letter_tx morse_letter_tx_chk #(
   .PAT_W (PAT_W),
   .TICKS (TICKS)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .start_i      (start_i),
   .serial_o     (serial_o),
   .bit_strobe_o (bit_strobe_o)
);

// File: tb/morse_letter_tx_tb.sv
`timescale 1ns/1ps
module morse_letter_tx_tb;
   localparam int HZ    = 4;
   localparam int TICKS = HZ / 2;
   localparam int W     = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [2:0] letter = '0;
   logic       serial;
   logic       strobe;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   bit fresh  = 0;
   int since  = 0;
   bit exp_q[$];

   always #2 clk = ~clk;

   morse_letter_tx #(.CLK_HZ(HZ), .PAT_W(W)) u_dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .start_i      (start),
      .letter_i     (letter),
      .serial_o     (serial),
      .bit_strobe_o (strobe)
   );

   function automatic logic [11:0] ref_pat(int l);
      case (l)
         0: return 12'b101110000000;
         1: return 12'b111010101000;
         2: return 12'b111010111010;
         3: return 12'b111010100000;
         4: return 12'b100000000000;
         5: return 12'b101011101000;
         6: return 12'b111011101000;
         default: return 12'b101010100000;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: queue expected bits, then pulse start for one cycle
   task automatic send(input int l);
      logic [11:0] p;
      @(negedge clk); #1;
      exp_q.delete();
      p = ref_pat(l);
      for (int i = W - 1; i >= 0; i--) exp_q.push_back(p[i]);
      fresh  = 1;
      since  = 0;
      letter = 3'(l);
      start  = 1'b1;
      @(negedge clk); #1;
      start  = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every strobed bit is popped and compared
   always @(negedge clk) begin
      if (!rst) begin
         if (strobe) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected strobe", 1, 0);
            end else begin
               bit e;
               e = exp_q.pop_front();
               check(serial == e, "R1/R2/R3 serial bit", int'(serial), int'(e));
            end
            if (!fresh) check(since == TICKS - 1, "R4 bit spacing", since, TICKS - 1);
            fresh = 0;
            since = 0;
         end else begin
            since = since + 1;
         end
      end
   end

   initial begin
      idle(3);
      check(serial == 1'b0, "R7 reset serial", int'(serial), 0);
      check(strobe == 1'b0, "R7 reset strobe", int'(strobe), 0);
      @(negedge clk); #1 rst = 1'b0;

      // every letter, full pattern
      for (int l = 0; l < 8; l++) begin
         send(l);
         idle(30);
         check(exp_q.size() == 0, "R5 twelve strobes", exp_q.size(), 0);
         check(serial == 1'b0, "R6 idle serial", int'(serial), 0);
      end

      // restart mid-stream: C interrupted by G
      send(2);
      idle(5);
      send(6);
      idle(30);
      check(exp_q.size() == 0, "R8 restart completes", exp_q.size(), 0);

      // reset together with start: reset wins
      @(negedge clk); #1;
      rst = 1'b1; start = 1'b1; letter = 3'd7;
      exp_q.delete();
      @(negedge clk); #1;
      rst = 1'b0; start = 1'b0;
      check(serial == 1'b0 && strobe == 1'b0, "R7 reset beats start",
            int'(serial) + int'(strobe), 0);
      idle(10);
      check(serial == 1'b0, "R7 no load after reset", int'(serial), 0);

      // reset in the middle of a letter
      send(1);
      idle(7);
      @(negedge clk); #1;
      rst = 1'b1;
      exp_q.delete();
      @(negedge clk); #1;
      rst = 1'b0;
      idle(30);
      check(serial == 1'b0, "R7 mid reset serial", int'(serial), 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule